// File: doc/BRIEF.md
# Battery State Supervisor

This block watches the battery condition of a handheld payment terminal and turns it into user-facing warnings and a controlled shutdown. A two-bit level code from the power monitor tells the block whether the battery is healthy, running low, or critically low. A second input reports whether the charger is connected. The block is a synchronous Moore state machine, so every output is a decode of the registered state.

With a healthy battery the block lights the green status lamp. At a low level it asks the display to tell the user to finish and pay, or to move to another terminal. At a critical level it raises a final warning for a fixed number of cycles. It then emits a one-cycle request to wipe session data and drop the secure link, and after that a held power-off request. Connecting the charger overrides every state, including an active countdown. Disconnecting it resumes the state that matches the level present at that moment, not the state held before charging.

Top module: `bat_supervisor`

## Requirements
- R1: At most one of the five outputs (`led_green`, `low_msg`, `final_warn`, `wipe_pulse`, `power_off`) is high in any cycle. In the charging state all five are low.
- R2: If `charger_on` is high at a clock edge, the block is in the charging state after that edge, whatever state it was in before (including power-off).
- R3: If `charger_on` is low at a clock edge while the block is charging, the next state follows the level sampled at that edge: 2'b00 gives the good state, 2'b01 the low state, and 2'b10 or 2'b11 the critical warning.
- R4: In the good state only `led_green` is high.
- R5: In the low state only `low_msg` is high. Outside the warning and shutdown sequence, the good and low states follow the level input one edge later.
- R6: Once entered, the critical warning keeps `final_warn` high for exactly `WARN_CYCLES` consecutive cycles. Level changes during the warning have no effect on it.
- R7: `wipe_pulse` is high for exactly one cycle, in the cycle right after the last warning cycle. `power_off` rises in the next cycle and stays high until reset or the charger is connected.
- R8: Connecting the charger during the warning aborts the shutdown: no `wipe_pulse` follows, and the block goes to the charging state.
- R9: Reset is synchronous and active-low. While `rst_n` is low at an edge, the state is loaded from the level input using the same mapping as R3, and the warning counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| level | input | 2 | Battery level code: 00 good, 01 low, 10/11 critical |
| charger_on | input | 1 | Charger connected |
| led_green | output | 1 | Green status lamp, good state |
| low_msg | output | 1 | Request for the low-battery message |
| final_warn | output | 1 | Final warning before shutdown |
| wipe_pulse | output | 1 | One-cycle request to clear data and drop the link |
| power_off | output | 1 | Held power-off request |

## Verification
The assertions assume that `level` and `charger_on` are synchronous to `clk` and settle before each rising edge. They also assume that `WARN_CYCLES` is at least one, and that no check needs to be evaluated while `rst_n` is low. The bench changes both inputs only on falling edges and samples outputs just after rising edges. It drives the reserved level code 2'b11 on purpose, to confirm that this code is treated as critical.

// File: rtl/bat_sup_pkg.sv
// Package: shared state type and level codes for the battery supervisor.
// Assumes the level code is two bits wide.
package bat_sup_pkg;

    localparam int LVL_W = 2;

    localparam logic [LVL_W-1:0] LVL_GOOD = 2'b00;
    localparam logic [LVL_W-1:0] LVL_LOW  = 2'b01;
    localparam logic [LVL_W-1:0] LVL_CRIT = 2'b10;

    typedef enum logic [2:0] {
        ST_GOOD   = 3'd0,
        ST_LOW    = 3'd1,
        ST_WARN   = 3'd2,
        ST_WIPE   = 3'd3,
        ST_OFF    = 3'd4,
        ST_CHARGE = 3'd5
    } bat_state_t;

endpackage

// File: rtl/bat_level_map.sv
// Maps the battery level code to the matching run state.
// Assumes that any code other than good or low (including the reserved
// code 11) means a critical battery.
module bat_level_map
    import bat_sup_pkg::*;
(
    input  logic [LVL_W-1:0] level,
    output bat_state_t       lvl_state
);

    // Pick the level state; unknown codes fall to the safe critical side.
    always_comb begin
        case (level)
            LVL_GOOD: lvl_state = ST_GOOD;
            LVL_LOW:  lvl_state = ST_LOW;
            default:  lvl_state = ST_WARN;
        endcase
    end

endmodule

// File: rtl/bat_warn_timer.sv
// Counts cycles spent in the critical warning and flags the last one.
// Assumes WARN_CYCLES >= 1. The count clears whenever run is low, so
// every new warning starts again from zero.
module bat_warn_timer #(
    parameter int WARN_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    localparam int CNT_W = $clog2(WARN_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WARN_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count warning cycles; hold at the last value, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The current cycle is the last warning cycle.
    assign last = run && (cnt == LAST_VAL);

endmodule

// File: rtl/bat_out_decode.sv
// Moore output decode: one indication per state, none while charging.
module bat_out_decode
    import bat_sup_pkg::*;
(
    input  bat_state_t state,
    output logic       led_green,
    output logic       low_msg,
    output logic       final_warn,
    output logic       wipe_pulse,
    output logic       power_off
);

    // Drive exactly one indication from the state, or none.
    always_comb begin
        led_green  = 1'b0;
        low_msg    = 1'b0;
        final_warn = 1'b0;
        wipe_pulse = 1'b0;
        power_off  = 1'b0;
        case (state)
            ST_GOOD: led_green  = 1'b1;
            ST_LOW:  low_msg    = 1'b1;
            ST_WARN: final_warn = 1'b1;
            ST_WIPE: wipe_pulse = 1'b1;
            ST_OFF:  power_off  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bat_supervisor.sv
// Battery supervisor top: Moore FSM with a charging override and a
// staged critical shutdown (warning, wipe, power-off).
// Assumes level and charger_on are synchronous to clk. Reset is
// synchronous and active-low, and it loads the level-matching state.
module bat_supervisor
    import bat_sup_pkg::*;
#(
    parameter int WARN_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             charger_on,
    output logic             led_green,
    output logic             low_msg,
    output logic             final_warn,
    output logic             wipe_pulse,
    output logic             power_off
);

    bat_state_t state, state_nx, lvl_state;
    logic       warn_last;

    bat_level_map u_map (
        .level     (level),
        .lvl_state (lvl_state)
    );

    bat_warn_timer #(.WARN_CYCLES(WARN_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WARN),
        .last  (warn_last)
    );

    // Next-state rule: the charger overrides; otherwise per-state moves.
    always_comb begin
        state_nx = state;
        if (charger_on) begin
            state_nx = ST_CHARGE;
        end else begin
            case (state)
                ST_GOOD, ST_LOW, ST_CHARGE: state_nx = lvl_state;
                ST_WARN: if (warn_last) state_nx = ST_WIPE;
                ST_WIPE: state_nx = ST_OFF;
                ST_OFF:  state_nx = ST_OFF;
                default: state_nx = lvl_state;
            endcase
        end
    end

    // State register; reset loads the state matching the present level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= lvl_state;
        end else begin
            state <= state_nx;
        end
    end

    bat_out_decode u_dec (
        .state      (state),
        .led_green  (led_green),
        .low_msg    (low_msg),
        .final_warn (final_warn),
        .wipe_pulse (wipe_pulse),
        .power_off  (power_off)
    );

endmodule

// File: rtl/bat_supervisor_chk.sv
// Checker for bat_supervisor, attached with bind. It uses only the
// top-level ports and its own run counter.
module bat_supervisor_chk #(
    parameter int WARN_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] level,
    input logic       charger_on,
    input logic       led_green,
    input logic       low_msg,
    input logic       final_warn,
    input logic       wipe_pulse,
    input logic       power_off
);

    int warn_run;

    // Length of the current unbroken run of final_warn cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !final_warn) warn_run <= 0;
        else                       warn_run <= warn_run + 1;
    end

    // R1
    one_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({led_green, low_msg, final_warn, wipe_pulse, power_off}));

    // R2
    charge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        charger_on |=> !(led_green | low_msg | final_warn | wipe_pulse | power_off));

    // R4
    good_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_green && !charger_on && level == 2'b00) |=> led_green);

    // R6
    warn_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        final_warn |-> warn_run < WARN_CYCLES);

    // R6
    warn_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wipe_pulse) |-> warn_run == WARN_CYCLES);

    // R7
    wipe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_pulse |=> !wipe_pulse);

    // R7
    off_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_pulse && !charger_on) |=> power_off);

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (final_warn && charger_on) |=> !wipe_pulse);

endmodule

bind bat_supervisor bat_supervisor_chk #(.WARN_CYCLES(WARN_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (level),
    .charger_on (charger_on),
    .led_green  (led_green),
    .low_msg    (low_msg),
    .final_warn (final_warn),
    .wipe_pulse (wipe_pulse),
    .power_off  (power_off)
);

// File: tb/bat_supervisor_test.sv
// Bench for bat_supervisor: a table of level/charger steps, then
// directed tests for reset, the warning countdown, abort and power-off.
module bat_supervisor_test;

    localparam int CLK_PERIOD = 10;
    localparam int WARN_N     = 5;

    // Output pattern order: {green, low, warn, wipe, off}.
    localparam logic [4:0] O_GOOD = 5'b10000;
    localparam logic [4:0] O_LOW  = 5'b01000;
    localparam logic [4:0] O_WARN = 5'b00100;
    localparam logic [4:0] O_WIPE = 5'b00010;
    localparam logic [4:0] O_OFF  = 5'b00001;
    localparam logic [4:0] O_CHG  = 5'b00000;

    // Vector: {level[1:0], charger, expected[4:0]}.
    localparam int NVEC = 9;
    localparam logic [7:0] VECS [NVEC] = '{
        {2'b00, 1'b0, O_GOOD},
        {2'b01, 1'b0, O_LOW },
        {2'b01, 1'b1, O_CHG },
        {2'b00, 1'b1, O_CHG },
        {2'b00, 1'b0, O_GOOD},
        {2'b01, 1'b0, O_LOW },
        {2'b00, 1'b1, O_CHG },
        {2'b01, 1'b0, O_LOW },
        {2'b00, 1'b0, O_GOOD}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] level = 2'b00;
    logic       charger_on = 1'b0;
    logic       led_green, low_msg, final_warn, wipe_pulse, power_off;
    int         n_run = 0;
    int         n_fail = 0;

    bat_supervisor #(.WARN_CYCLES(WARN_N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .charger_on (charger_on),
        .led_green  (led_green),
        .low_msg    (low_msg),
        .final_warn (final_warn),
        .wipe_pulse (wipe_pulse),
        .power_off  (power_off)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {led_green, low_msg, final_warn, wipe_pulse, power_off};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    // Drive on the falling edge, sample just after the rising edge.
    task automatic step(input logic [1:0] lv, input logic chg);
        @(negedge clk);
        level = lv;
        charger_on = chg;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] lv);
        @(negedge clk);
        rst_n = 1'b0;
        level = lv;
        charger_on = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R9: reset loads the level-matching state
        do_reset(2'b00);
        #1 check("R9 reset good", O_GOOD);
        do_reset(2'b01);
        #1 check("R9 reset low", O_LOW);
        do_reset(2'b00);

        // Table walk: R2 R3 R4 R5 (resume follows present level)
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i][7:6], VECS[i][5]);
            check("R2/R3/R4/R5 vector", VECS[i][4:0]);
        end

        // R6: warning lasts WARN_N cycles, level changes ignored
        step(2'b10, 1'b0);
        check("R6 warn enter", O_WARN);
        for (int k = 1; k < WARN_N; k++) begin
            step(2'b00, 1'b0);
            check("R6 warn hold", O_WARN);
        end
        // R7: one wipe cycle, then held power-off
        step(2'b00, 1'b0);
        check("R7 wipe", O_WIPE);
        step(2'b00, 1'b0);
        check("R7 off", O_OFF);
        step(2'b00, 1'b0);
        check("R7 off held", O_OFF);
        // R2: charger wakes from off; R3: resume good
        step(2'b00, 1'b1);
        check("R2 charge from off", O_CHG);
        step(2'b00, 1'b0);
        check("R3 resume good", O_GOOD);

        // R8: charger during warning aborts; R3: reserved 11 is critical
        step(2'b11, 1'b0);
        check("R3 code 11 critical", O_WARN);
        step(2'b11, 1'b0);
        check("R6 warn", O_WARN);
        step(2'b11, 1'b1);
        check("R8 abort to charge", O_CHG);
        step(2'b10, 1'b0);
        check("R3 resume warn", O_WARN);
        for (int k = 1; k < WARN_N; k++) begin
            step(2'b10, 1'b0);
            check("R6 restarted count", O_WARN);
        end
        step(2'b10, 1'b1);
        check("R8 abort at last cycle", O_CHG);
        step(2'b01, 1'b0);
        check("R1 resume low single ind", O_LOW);

        // R9: reset straight into critical
        do_reset(2'b10);
        #1 check("R9 reset critical", O_WARN);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule